// File: doc/BRIEF.md
# UART Task/Event Register Front End

This block is the register-facing control layer of a simple UART. Software drives it through a word-addressed 32-bit register bus with write and read strobes. Single-shot "task" words start or stop the receiver and the transmitter. Hardware raises "event" flags that software clears by writing them. A single level interrupt output combines those flags, and each flag has its own mask bit. The serial engines sit beside this block. The transmitter takes bytes over a valid/ready handoff and reports each finished byte with a done pulse. The receiver reports a line break on a one-cycle input. The `rx_run` and `tx_run` outputs tell the engines whether each direction is started.

The peripheral stays off until software writes the enable code 4 to the enable word. While it is off, it answers every read with zero and drops every write except writes to the enable word. Writing zero to the enable word turns it off and stops both directions, in the same way as a suspend.

Top module: `uart_task_regs`

## Requirements
- R1: After reset, irq, tx_valid, rx_run and tx_run are 0. Once the peripheral is enabled, the interrupt mask, the event flags, the error source and transmit data read 0. The baud word (word 0x149) reads 0x04000000 and the four pin-select words (0x142..0x145) read 0xFFFFFFFF.
- R2: Writing 4 to the enable word (word 0x140) turns the peripheral on, and reads of that word then return 4. Writing 0 turns it off, clears rx_run and tx_run, and sets the receive-timeout flag. Any other value is ignored.
- R3: While the peripheral is off, every read returns 0 and every write to a word other than the enable word has no effect.
- R4: Writing exactly 1 to word 0 sets rx_run, and writing exactly 1 to word 2 sets tx_run. Any other value leaves both unchanged.
- R5: Writing 1 to word 1 clears rx_run and sets the receive-timeout flag. Writing 1 to word 3 clears tx_run only. Writing 1 to word 7 clears both and sets the receive-timeout flag.
- R6: The event words are receive-ready (0x42), transmit-ready (0x47), error (0x49) and receive-timeout (0x51). Each reads 1 or 0. A write of a nonzero value sets the flag, and a write of zero clears it.
- R7: The mask bits are receive-ready bit 2, transmit-ready bit 7, error bit 9 and receive-timeout bit 17; all other bits read 0. Word 0xC0 loads the mask, word 0xC1 ORs the written bits into it, and word 0xC2 clears the written bits. Reads of all three words return the mask.
- R8: irq is the OR, over the four events, of the flag AND its mask bit. It follows each write or hardware event one clock later.
- R9: A write to word 0x147 captures the low byte only while tx_run is 1 and no byte is pending. tx_valid then stays high with tx_data stable until tx_ready is seen. A tx_done pulse while a byte is pending sets transmit-ready and allows the next byte.
- R10: A brk_det pulse sets error source bits [1:0] (word 0x120) and the error flag. Writing 1s to the error source word clears those bits.
- R11: Writes to unmapped words are ignored and unmapped words read 0. The baud, pin-select and configuration (0x15B) words store what is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Word address inside the 4 KB window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| irq | output | 1 | Level interrupt |
| rx_run | output | 1 | Receiver started |
| tx_run | output | 1 | Transmitter started |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | TX_W | Transmit byte |
| tx_ready | input | 1 | Serial transmitter takes the byte |
| tx_done | input | 1 | One-cycle pulse: byte sent |
| brk_det | input | 1 | One-cycle pulse: line break seen |

## Verification
The bench builds the block with its default TX_W of 8, so the captured transmit byte can be compared directly with the low byte of the bus write. Byte values such as 0xA5 and 0x5A show at once whether a rejected second write leaked into tx_data. The default 10-bit word address covers the whole 4 KB window, so mapped and unmapped words can both be reached. With these defaults, a random mix of flag and mask writes reaches every combination of the four events and four mask bits.

// File: rtl/uart_tr_pkg.sv
package uart_tr_pkg;
  localparam int AW      = 10;
  localparam int DW      = 32;
  localparam int NUM_EVT = 4;
  localparam int NUM_CFG = 6;

  localparam int EV_RXRDY = 0;
  localparam int EV_TXRDY = 1;
  localparam int EV_ERR   = 2;
  localparam int EV_RXTO  = 3;

  localparam logic [AW-1:0] A_START_RX = 10'h000;
  localparam logic [AW-1:0] A_STOP_RX  = 10'h001;
  localparam logic [AW-1:0] A_START_TX = 10'h002;
  localparam logic [AW-1:0] A_STOP_TX  = 10'h003;
  localparam logic [AW-1:0] A_SUSPEND  = 10'h007;
  localparam logic [AW-1:0] A_MASK     = 10'h0C0;
  localparam logic [AW-1:0] A_MASK_SET = 10'h0C1;
  localparam logic [AW-1:0] A_MASK_CLR = 10'h0C2;
  localparam logic [AW-1:0] A_ERRSRC   = 10'h120;
  localparam logic [AW-1:0] A_ENABLE   = 10'h140;
  localparam logic [AW-1:0] A_TXBYTE   = 10'h147;

  localparam logic [DW-1:0] ON_CODE = 32'd4;

  function automatic logic [AW-1:0] evt_addr(input int e);
    case (e)
      EV_RXRDY: return 10'h042;
      EV_TXRDY: return 10'h047;
      EV_ERR:   return 10'h049;
      default:  return 10'h051;
    endcase
  endfunction

  function automatic int evt_bit(input int e);
    case (e)
      EV_RXRDY: return 2;
      EV_TXRDY: return 7;
      EV_ERR:   return 9;
      default:  return 17;
    endcase
  endfunction

  function automatic logic [AW-1:0] cfg_addr(input int i);
    case (i)
      0, 1, 2, 3: return 10'h142 + AW'(i);
      4:          return 10'h149;
      default:    return 10'h15B;
    endcase
  endfunction

  function automatic logic [DW-1:0] cfg_reset(input int i);
    case (i)
      0, 1, 2, 3: return 32'hFFFF_FFFF;
      4:          return 32'h0400_0000;
      default:    return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/uart_tr_ctrl.sv
module uart_tr_ctrl
  import uart_tr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ok,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          en_o,
  output logic          rx_run_o,
  output logic          tx_run_o,
  output logic          rxto_set_o
);
  logic en_q, en_d, rx_q, rx_d, tx_q, tx_d;
  logic is_one;

  assign is_one = (wdata == 32'd1);

  always_comb begin
    en_d       = en_q;
    rx_d       = rx_q;
    tx_d       = tx_q;
    rxto_set_o = 1'b0;
    if (wr_ok) begin
      case (addr)
        A_START_RX: if (is_one) rx_d = 1'b1;
        A_STOP_RX:  if (is_one) begin rx_d = 1'b0; rxto_set_o = 1'b1; end
        A_START_TX: if (is_one) tx_d = 1'b1;
        A_STOP_TX:  if (is_one) tx_d = 1'b0;
        A_SUSPEND:  if (is_one) begin rx_d = 1'b0; tx_d = 1'b0; rxto_set_o = 1'b1; end
        A_ENABLE: begin
          if (wdata == ON_CODE) begin
            en_d = 1'b1;
          end else if (wdata == '0) begin
            en_d = 1'b0; rx_d = 1'b0; tx_d = 1'b0; rxto_set_o = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      rx_q <= 1'b0;
      tx_q <= 1'b0;
    end else if (wr_ok) begin
      en_q <= en_d;
      rx_q <= rx_d;
      tx_q <= tx_d;
    end
  end

  assign en_o     = en_q;
  assign rx_run_o = rx_q;
  assign tx_run_o = tx_q;
endmodule

// File: rtl/uart_tr_events.sv
module uart_tr_events
  import uart_tr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] hw_set,
  input  logic [NUM_EVT-1:0] sw_we,
  input  logic               sw_val,
  input  logic [NUM_EVT-1:0] mask,
  output logic [NUM_EVT-1:0] flags,
  output logic               irq
);
  logic [NUM_EVT-1:0] flag_q, flag_d, flag_ce;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    always_comb begin
      flag_ce[i] = hw_set[i] | sw_we[i];
      flag_d[i]  = hw_set[i] ? 1'b1 : sw_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (flag_ce[i]) flag_q[i] <= flag_d[i];
    end
  end

  assign flags = flag_q;
  assign irq   = |(flag_q & mask);
endmodule

// File: rtl/uart_tr_txpath.sv
module uart_tr_txpath #(
  parameter int TX_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            run,
  input  logic [TX_W-1:0] wbyte,
  input  logic            tx_ready,
  input  logic            tx_done,
  output logic            tx_valid,
  output logic [TX_W-1:0] tx_data,
  output logic            pend,
  output logic            done_evt
);
  logic            pend_q, pend_d, sent_q, sent_d, accept, st_ce;
  logic [TX_W-1:0] byte_q;

  assign accept   = load & run & ~pend_q;
  assign done_evt = tx_done & pend_q;
  assign tx_valid = pend_q & ~sent_q;

  always_comb begin
    pend_d = pend_q;
    sent_d = sent_q;
    if (accept) begin
      pend_d = 1'b1;
      sent_d = 1'b0;
    end else begin
      if (tx_valid && tx_ready) sent_d = 1'b1;
      if (done_evt) begin
        pend_d = 1'b0;
        sent_d = 1'b0;
      end
    end
  end

  assign st_ce = accept | done_evt | (tx_valid & tx_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      sent_q <= 1'b0;
    end else if (st_ce) begin
      pend_q <= pend_d;
      sent_q <= sent_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      byte_q <= '0;
    else if (accept) byte_q <= wbyte;
  end

  assign tx_data = byte_q;
  assign pend    = pend_q;
endmodule

// File: rtl/uart_task_regs.sv
module uart_task_regs
  import uart_tr_pkg::*;
#(
  parameter int TX_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [9:0]      bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq,
  output logic            rx_run,
  output logic            tx_run,
  output logic            tx_valid,
  output logic [TX_W-1:0] tx_data,
  input  logic            tx_ready,
  input  logic            tx_done,
  input  logic            brk_det
);
  localparam int PAD_W = DW - TX_W;

  logic               en_q, wr_ok, rxto_set, tx_pend, done_evt;
  logic [NUM_EVT-1:0] evt_q, evt_we, hw_set, inten_q, inten_d, wmask;
  logic               inten_ce, errsrc_ce;
  logic [1:0]         errsrc_q, errsrc_d;
  logic [DW-1:0]      inten_wide, rdata_c;
  logic [DW-1:0]      cfg_q [NUM_CFG];

  assign wr_ok = bus_wr & (en_q | (bus_addr == A_ENABLE));

  uart_tr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .addr(bus_addr), .wdata(bus_wdata),
    .en_o(en_q), .rx_run_o(rx_run), .tx_run_o(tx_run), .rxto_set_o(rxto_set)
  );

  uart_tr_txpath #(.TX_W(TX_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .load(wr_ok && bus_addr == A_TXBYTE), .run(tx_run),
    .wbyte(bus_wdata[TX_W-1:0]), .tx_ready(tx_ready), .tx_done(tx_done),
    .tx_valid(tx_valid), .tx_data(tx_data), .pend(tx_pend), .done_evt(done_evt)
  );

  always_comb begin
    hw_set           = '0;
    hw_set[EV_TXRDY] = done_evt;
    hw_set[EV_ERR]   = brk_det;
    hw_set[EV_RXTO]  = rxto_set;
    for (int i = 0; i < NUM_EVT; i++) begin
      evt_we[i]  = wr_ok && (bus_addr == evt_addr(i));
      wmask[i]   = bus_wdata[evt_bit(i)];
    end
  end

  uart_tr_events u_evt (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .sw_we(evt_we),
    .sw_val(|bus_wdata), .mask(inten_q), .flags(evt_q), .irq(irq)
  );

  // interrupt mask: load / set / clear
  always_comb begin
    inten_d  = inten_q;
    inten_ce = 1'b0;
    if (wr_ok) begin
      case (bus_addr)
        A_MASK:     begin inten_d = wmask;            inten_ce = 1'b1; end
        A_MASK_SET: begin inten_d = inten_q | wmask;  inten_ce = 1'b1; end
        A_MASK_CLR: begin inten_d = inten_q & ~wmask; inten_ce = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        inten_q <= '0;
    else if (inten_ce) inten_q <= inten_d;
  end

  // error source: set by break, write-1-to-clear
  always_comb begin
    errsrc_d = errsrc_q;
    if (wr_ok && bus_addr == A_ERRSRC) errsrc_d = errsrc_d & ~bus_wdata[1:0];
    if (brk_det)                       errsrc_d = 2'b11;
    errsrc_ce = brk_det | (wr_ok && bus_addr == A_ERRSRC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         errsrc_q <= '0;
    else if (errsrc_ce) errsrc_q <= errsrc_d;
  end

  // plain storage words
  for (genvar c = 0; c < NUM_CFG; c++) begin : g_cfg
    logic ce;
    assign ce = wr_ok && (bus_addr == cfg_addr(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg_q[c] <= cfg_reset(c);
      else if (ce) cfg_q[c] <= bus_wdata;
    end
  end

  always_comb begin
    inten_wide = '0;
    for (int i = 0; i < NUM_EVT; i++) inten_wide[evt_bit(i)] = inten_q[i];
  end

  always_comb begin
    rdata_c = '0;
    if (bus_rd && en_q) begin
      for (int i = 0; i < NUM_EVT; i++)
        if (bus_addr == evt_addr(i)) rdata_c = {{(DW-1){1'b0}}, evt_q[i]};
      for (int c = 0; c < NUM_CFG; c++)
        if (bus_addr == cfg_addr(c)) rdata_c = cfg_q[c];
      case (bus_addr)
        A_MASK, A_MASK_SET, A_MASK_CLR: rdata_c = inten_wide;
        A_ERRSRC: rdata_c = {{(DW-2){1'b0}}, errsrc_q};
        A_ENABLE: rdata_c = ON_CODE;
        A_TXBYTE: rdata_c = {{PAD_W{1'b0}}, tx_data};
        default: ;
      endcase
    end
  end

  assign bus_rdata = rdata_c;
endmodule

// File: rtl/uart_task_regs_chk.sv
module uart_task_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [9:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        irq,
  input logic        rx_run,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        tx_done,
  input logic        brk_det,
  input logic [7:0]  tx_data,
  input logic        en_q,
  input logic [3:0]  inten_q,
  input logic [3:0]  evt_q,
  input logic [1:0]  errsrc_q,
  input logic        tx_pend
);
  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inten_q == 4'b0) |-> !irq);

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(bus_wr || brk_det || tx_done));

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R9
  tx_done_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && tx_pend) |=> evt_q[1]);

  // R3
  off_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && bus_rd) |-> (bus_rdata == 32'h0));

  // R5
  stop_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && bus_wr && bus_addr == 10'h001 && bus_wdata == 32'd1) |=> (!rx_run && evt_q[3]));

  // R10
  break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det |=> (evt_q[2] && errsrc_q == 2'b11));
endmodule

bind uart_task_regs uart_task_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rx_run(rx_run),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_done(tx_done), .brk_det(brk_det),
  .tx_data(tx_data[7:0]), .en_q(en_q), .inten_q(inten_q), .evt_q(evt_q),
  .errsrc_q(errsrc_q), .tx_pend(tx_pend)
);

// File: tb/uart_task_regs_bench.sv
module uart_task_regs_bench;
  localparam logic [9:0] W_SRX = 10'h000, W_PRX = 10'h001, W_STX = 10'h002,
                         W_PTX = 10'h003, W_SUS = 10'h007, W_RXR = 10'h042,
                         W_TXR = 10'h047, W_ERR = 10'h049, W_RTO = 10'h051,
                         W_MSK = 10'h0C0, W_MSET = 10'h0C1, W_MCLR = 10'h0C2,
                         W_ESRC = 10'h120, W_EN = 10'h140, W_PS0 = 10'h142,
                         W_TXB = 10'h147, W_BAUD = 10'h149, W_CFG = 10'h15B;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  bus_addr;
  logic        bus_wr, bus_rd, tx_ready, tx_done, brk_det;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, rx_run, tx_run, tx_valid;
  logic [7:0]  tx_data;
  int          errors = 0;
  int          checks = 0;
  logic [31:0] rv;
  logic [3:0]  m_ev, m_msk;

  always #2 clk = ~clk;

  uart_task_regs u_uart_task_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rx_run(rx_run),
    .tx_run(tx_run), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .tx_done(tx_done), .brk_det(brk_det)
  );

  function automatic logic [9:0] ev_word(input int e);
    case (e) 0: return W_RXR; 1: return W_TXR; 2: return W_ERR; default: return W_RTO; endcase
  endfunction

  function automatic logic [31:0] widen(input logic [3:0] m);
    logic [31:0] w = '0;
    w[2] = m[0]; w[7] = m[1]; w[9] = m[2]; w[17] = m[3];
    return w;
  endfunction

  function automatic logic [3:0] squeeze(input logic [31:0] w);
    return {w[17], w[9], w[7], w[2]};
  endfunction

  function automatic logic exp_irq(input logic [3:0] ev, input logic [3:0] m);
    return |(ev & m);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_done();
    tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    tx_ready = 0; tx_done = 0; brk_det = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset outputs
    chk("R1 irq", irq, 0); chk("R1 tx_valid", tx_valid, 0);
    chk("R1 rx_run", rx_run, 0); chk("R1 tx_run", tx_run, 0);

    // R3 off: reads zero, writes dropped
    rd(W_BAUD, rv); chk("R3 off read", rv, 0);
    wr(W_MSK, 32'hFFFF_FFFF); wr(W_STX, 1); wr(W_RXR, 1);
    chk("R3 off task", tx_run, 0); chk("R3 off irq", irq, 0);

    // R2 enable codes
    wr(W_EN, 5); rd(W_EN, rv); chk("R2 bad code", rv, 0);
    wr(W_EN, 4); rd(W_EN, rv); chk("R2 on", rv, 4);

    // R1 reset values, R3 dropped writes left nothing
    rd(W_BAUD, rv); chk("R1 baud", rv, 32'h0400_0000);
    for (int p = 0; p < 4; p++) begin
      rd(W_PS0 + 10'(p), rv); chk("R1 pinsel", rv, 32'hFFFF_FFFF);
    end
    rd(W_MSK, rv); chk("R3 mask kept", rv, 0);
    rd(W_RXR, rv); chk("R3 event kept", rv, 0);
    rd(W_ESRC, rv); chk("R1 errsrc", rv, 0);
    rd(W_TXB, rv); chk("R1 txbyte", rv, 0);

    // R11 unmapped and storage words
    wr(10'h200, 32'h1234_5678); rd(10'h200, rv); chk("R11 unmapped", rv, 0);
    wr(W_BAUD, 32'h0100_0000); rd(W_BAUD, rv); chk("R11 baud", rv, 32'h0100_0000);
    wr(W_CFG, 32'h0000_000E); rd(W_CFG, rv); chk("R11 cfg", rv, 32'h0000_000E);

    // R4 start tasks
    wr(W_SRX, 2); chk("R4 value2", rx_run, 0);
    wr(W_SRX, 1); chk("R4 rx", rx_run, 1);
    wr(W_STX, 1); chk("R4 tx", tx_run, 1);

    // R5 stop tasks
    wr(W_PTX, 1); chk("R5 stoptx tx", tx_run, 0); chk("R5 stoptx rx", rx_run, 1);
    rd(W_RTO, rv); chk("R5 no rxto", rv, 0);
    wr(W_PRX, 1); chk("R5 stoprx", rx_run, 0);
    rd(W_RTO, rv); chk("R5 rxto", rv, 1);
    wr(W_RTO, 0);
    wr(W_SRX, 1); wr(W_STX, 1); wr(W_SUS, 1);
    chk("R5 suspend rx", rx_run, 0); chk("R5 suspend tx", tx_run, 0);
    rd(W_RTO, rv); chk("R5 suspend rxto", rv, 1);
    wr(W_RTO, 0);

    // R2 disable stops both
    wr(W_SRX, 1); wr(W_STX, 1); wr(W_EN, 0);
    chk("R2 off rx", rx_run, 0); chk("R2 off tx", tx_run, 0);
    wr(W_EN, 4); rd(W_RTO, rv); chk("R2 off rxto", rv, 1);
    wr(W_RTO, 0);

    // R9 transmit handoff
    wr(W_TXB, 32'h77); chk("R9 not started", tx_valid, 0);
    wr(W_STX, 1);
    wr(W_TXB, 32'hA5); chk("R9 valid", tx_valid, 1); chk("R9 data", tx_data, 8'hA5);
    wr(W_TXB, 32'h5A); chk("R9 pending drop", tx_data, 8'hA5);
    @(negedge clk); chk("R9 hold", tx_valid, 1);
    tx_ready = 1; @(negedge clk); tx_ready = 0;
    chk("R9 taken", tx_valid, 0);
    rd(W_TXR, rv); chk("R9 no early txrdy", rv, 0);
    pulse_done();
    rd(W_TXR, rv); chk("R9 txrdy", rv, 1);
    wr(W_TXB, 32'h3C); chk("R9 next", tx_data, 8'h3C);
    tx_ready = 1; @(negedge clk); tx_ready = 0; pulse_done();
    wr(W_TXR, 0); rd(W_TXR, rv); chk("R6 clear", rv, 0);

    // R10 break and error source
    brk_det = 1; @(negedge clk); brk_det = 0;
    rd(W_ERR, rv); chk("R10 error", rv, 1);
    rd(W_ESRC, rv); chk("R10 src", rv, 3);
    wr(W_ESRC, 1); rd(W_ESRC, rv); chk("R10 w1c", rv, 2);
    wr(W_ESRC, 2); rd(W_ESRC, rv); chk("R10 w1c all", rv, 0);
    wr(W_ERR, 0);

    // R7 mask access
    wr(W_MSK, 32'hFFFF_FFFF);
    rd(W_MSK, rv); chk("R7 load", rv, 32'h0002_0284);
    rd(W_MSET, rv); chk("R7 alias set", rv, 32'h0002_0284);
    rd(W_MCLR, rv); chk("R7 alias clr", rv, 32'h0002_0284);
    wr(W_MCLR, 32'h80); rd(W_MSK, rv); chk("R7 clr", rv, 32'h0002_0204);
    wr(W_MSET, 32'h80); rd(W_MSK, rv); chk("R7 set", rv, 32'h0002_0284);
    wr(W_MSK, 0);

    // R8 / R6 random events and masks
    m_ev = '0; m_msk = '0;
    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 4;
      logic [31:0] v = ($urandom % 3 == 0) ? 32'h0 : $urandom;
      if (op <= 1) begin
        int e = $urandom % 4;
        wr(ev_word(e), v); m_ev[e] = |v;
        if (it % 5 == 0) begin rd(ev_word(e), rv); chk("R6 flag", rv, {31'b0, m_ev[e]}); end
      end else if (op == 2) begin
        int k = $urandom % 3;
        logic [31:0] w = $urandom;
        if (k == 0)      begin wr(W_MSK, w);  m_msk = squeeze(w); end
        else if (k == 1) begin wr(W_MSET, w); m_msk = m_msk | squeeze(w); end
        else             begin wr(W_MCLR, w); m_msk = m_msk & ~squeeze(w); end
        if (it % 4 == 0) begin rd(W_MSK, rv); chk("R7 random", rv, widen(m_msk)); end
      end else begin
        @(negedge clk);
      end
      chk("R8 irq", irq, exp_irq(m_ev, m_msk));
    end

    finish_run();
  end
endmodule